// File: doc/BRIEF.md
# Coprocessor Instruction Trap Dispatcher

This block sits in the decode and issue path of a CPU. For every numeric-coprocessor instruction it decides whether the instruction goes to the coprocessor or raises a trap, and which trap vector applies. It looks at four things: the instruction class, two control-register bits (emulate and task-switched), a pending unmasked numeric-error flag, and, in protected mode, the operand's placement within its segment.

Decode presents one instruction per cycle with `instValid` high. One cycle later the block answers with exactly one of two results. Either `trapValid` pulses with an 8-bit vector, or `issuePermit` pulses to let the instruction proceed. Segment checks cover both the first word of the operand and operands that wrap around the top of the 16-bit offset space. Page checks, stack pushes and handler entry belong to other blocks.

Class encoding on `instClass`: 0 = escape (coprocessor opcode), 1 = WAIT, 2 = no-wait control form (initialize, clear exceptions, store status, store environment, save), 3 = reserved and handled like an escape.

Top module: `cop_trap_dispatch`

## Requirements
- R1: An escape (class 0 or 3) or no-wait form (class 2) with `ctlEm` high raises vector 7. A WAIT (class 1) ignores `ctlEm`.
- R2: With `ctlTs` high, an instruction of any class raises vector 7.
- R3: In protected mode, for a non-WAIT instruction with `memOp` high, vector 13 is raised and the instruction is not issued in two cases. The first is when either byte of the operand's first word (offset, offset+1 modulo 2^16) lies outside the segment. The second is when the operand does not wrap past offset FFFFh but any of its bytes lies outside the segment. With `protMode` low, no segment check applies.
- R4: In protected mode, if the first word is inside the segment but the operand wraps past FFFFh (offset + length > 10000h) and any byte lies outside the segment, vector 9 is raised. Example: limit FFFDh, offset FFFCh, length 8 gives vector 9. An expand-up segment with limit FFFFh never faults.
- R5: For an expand-up segment (`expandDown` = 0), the valid offsets are 0 to the limit inclusive. For an expand-down segment, the valid offsets run from limit+1 to FFFFh, so a wrapped byte at offset 0 is always outside the segment.
- R6: `fpErrPending` raises vector 16 for escape and WAIT instructions. A no-wait form never raises vector 16.
- R7: Priority is vector 7, then 13, then 9, then 16. At most one vector is reported per instruction.
- R8: Results are registered. `trapValid` or `issuePermit` is high for exactly one cycle, in the cycle after `instValid` was high. The two are never high together, and both stay low after a cycle with `instValid` low.
- R9: A WAIT instruction, or any instruction with `memOp` low, skips the segment checks.
- R10: During and right after reset, `trapValid`, `issuePermit` and `trapVector` are 0. `trapVector` also reads 0 in every cycle without a trap.
- R11: `opLen` is 2, 4, 8 or 10 bytes. All offset arithmetic is modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is presented this cycle |
| instClass | input | 2 | 0 escape, 1 WAIT, 2 no-wait form, 3 reserved (treated as escape) |
| ctlEm | input | 1 | Emulate bit from the control register |
| ctlTs | input | 1 | Task-switched bit from the control register |
| fpErrPending | input | 1 | An unmasked numeric error is pending |
| protMode | input | 1 | Protected mode enabled |
| memOp | input | 1 | Instruction has a memory operand |
| opOffset | input | 16 | Operand start offset |
| opLen | input | 4 | Operand length in bytes |
| segLimit | input | 16 | Segment limit |
| expandDown | input | 1 | Segment expands downward |
| trapValid | output | 1 | One-cycle trap strobe |
| trapVector | output | 8 | Trap vector number (0 when no trap) |
| issuePermit | output | 1 | One-cycle strobe: instruction may go to the coprocessor |

## Verification
The assertions check the following on every cycle:
- the control raises at most one vector selection;
- a trap and an issue never appear together;
- every result traces back to an `instValid` one cycle earlier;
- a vector 7 result had a matching control bit;
- a vector 9 or 13 result had protected mode and a memory operand;
- a vector 16 result never came from a no-wait form.

Only the bench's scenarios can show that the right vector is chosen from segment geometry. This covers expand-down ranges, the wrapped worked case, tail overruns without wrap, and the exact priority order when several causes coincide. These are checked against a behavioural model on every clock.

// File: rtl/cop_trap_pkg.sv
package cop_trap_pkg;

  typedef enum logic [1:0] {
    CLS_ESC    = 2'd0,
    CLS_WAIT   = 2'd1,
    CLS_NOWAIT = 2'd2,
    CLS_RSVD   = 2'd3
  } instClass_t;

  // Segment verdict from the datapath
  typedef struct packed {
    logic genFault;   // first word outside, or non-wrapping overrun
    logic wrapFault;  // wrapped operand touches an invalid byte
  } segStatus_t;

  // Strobes from control to the datapath output stage
  typedef struct packed {
    logic takeNm;
    logic takeGp;
    logic takeOvr;
    logic takeMf;
    logic issue;
  } trapSel_t;

endpackage

// File: rtl/cop_trap_control.sv
module cop_trap_control
  import cop_trap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [1:0] instClass,
  input  logic       ctlEm,
  input  logic       ctlTs,
  input  logic       fpErrPending,
  input  logic       protMode,
  input  logic       memOp,
  input  segStatus_t segStatus,
  output trapSel_t   trapSel
);

  instClass_t cls;
  logic isWait, isNoWait;
  logic segChecked, segHit;
  logic wantNm, wantGp, wantOvr, wantMf;

  always_comb begin
    cls        = instClass_t'(instClass);
    isWait     = (cls == CLS_WAIT);
    isNoWait   = (cls == CLS_NOWAIT);
    segChecked = protMode && memOp && !isWait;
    segHit     = segChecked && (segStatus.genFault || segStatus.wrapFault);

    wantNm  = (ctlEm && !isWait) || ctlTs;
    wantGp  = !wantNm && segChecked && segStatus.genFault;
    wantOvr = !wantNm && !wantGp && segChecked && segStatus.wrapFault;
    wantMf  = !wantNm && !segHit && fpErrPending && !isNoWait;

    trapSel.takeNm  = instValid && wantNm;
    trapSel.takeGp  = instValid && wantGp;
    trapSel.takeOvr = instValid && wantOvr;
    trapSel.takeMf  = instValid && wantMf;
    trapSel.issue   = instValid && !(wantNm || wantGp || wantOvr || wantMf);
  end

  assert_single_vector_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trapSel.takeNm, trapSel.takeGp, trapSel.takeOvr, trapSel.takeMf, trapSel.issue}));

  assert_nowait_no_mf_R6: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instClass == 2'd2) |-> !trapSel.takeMf);

endmodule

// File: rtl/cop_trap_datapath.sv
module cop_trap_datapath
  import cop_trap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 10,
  parameter int LEN_W   = 4,
  parameter int VEC_NM  = 7,
  parameter int VEC_OVR = 9,
  parameter int VEC_GP  = 13,
  parameter int VEC_MF  = 16,
  parameter int VEC_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] opOffset,
  input  logic [LEN_W-1:0]  opLen,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic              expandDown,
  input  trapSel_t          trapSel,
  output segStatus_t        segStatus,
  output logic              trapValid,
  output logic [VEC_W-1:0]  trapVector,
  output logic              issuePermit
);

  localparam int SUM_W = ADDR_W + 1;

  logic [MAX_LEN-1:0] byteBad;
  logic [SUM_W-1:0]   endSum;
  logic               wraps, firstBad, anyBad;

  // One range check per possible operand byte
  for (genvar i = 0; i < MAX_LEN; i++) begin : g_byte
    logic [ADDR_W-1:0] byteAddr;
    logic              inSeg;
    always_comb begin
      byteAddr   = opOffset + ADDR_W'(i);
      inSeg      = expandDown ? (byteAddr > segLimit) : (byteAddr <= segLimit);
      byteBad[i] = (LEN_W'(i) < opLen) && !inSeg;
    end
  end

  always_comb begin
    endSum   = {1'b0, opOffset} + SUM_W'(opLen);
    wraps    = endSum > SUM_W'(1 << ADDR_W);
    firstBad = byteBad[0] || byteBad[1];
    anyBad   = |byteBad;
    segStatus.genFault  = firstBad || (anyBad && !wraps);
    segStatus.wrapFault = !firstBad && anyBad && wraps;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapValid   <= 1'b0;
      trapVector  <= '0;
      issuePermit <= 1'b0;
    end else begin
      trapValid   <= trapSel.takeNm || trapSel.takeGp || trapSel.takeOvr || trapSel.takeMf;
      issuePermit <= trapSel.issue;
      if (trapSel.takeNm)       trapVector <= VEC_W'(VEC_NM);
      else if (trapSel.takeGp)  trapVector <= VEC_W'(VEC_GP);
      else if (trapSel.takeOvr) trapVector <= VEC_W'(VEC_OVR);
      else if (trapSel.takeMf)  trapVector <= VEC_W'(VEC_MF);
      else                      trapVector <= '0;
    end
  end

  assert_seg_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(segStatus.genFault && segStatus.wrapFault));

  assert_issue_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    issuePermit |-> !trapValid);

  assert_vector_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |-> (trapVector == '0));

endmodule

// File: rtl/cop_trap_dispatch.sv
module cop_trap_dispatch
  import cop_trap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 10,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [1:0]        instClass,
  input  logic              ctlEm,
  input  logic              ctlTs,
  input  logic              fpErrPending,
  input  logic              protMode,
  input  logic              memOp,
  input  logic [ADDR_W-1:0] opOffset,
  input  logic [LEN_W-1:0]  opLen,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic              expandDown,
  output logic              trapValid,
  output logic [7:0]        trapVector,
  output logic              issuePermit
);

  segStatus_t segStatus;
  trapSel_t   trapSel;

  cop_trap_control u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .ctlEm(ctlEm), .ctlTs(ctlTs), .fpErrPending(fpErrPending),
    .protMode(protMode), .memOp(memOp), .segStatus(segStatus), .trapSel(trapSel)
  );

  cop_trap_datapath #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .opOffset(opOffset), .opLen(opLen),
    .segLimit(segLimit), .expandDown(expandDown), .trapSel(trapSel),
    .segStatus(segStatus), .trapValid(trapValid), .trapVector(trapVector),
    .issuePermit(issuePermit)
  );

  assert_strobe_origin_R8: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid || issuePermit) |-> $past(instValid));

  assert_nm_cause_R1: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && trapVector == 8'd7) |-> $past(ctlTs || (ctlEm && instClass != 2'd1)));

  assert_seg_prot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && (trapVector == 8'd13 || trapVector == 8'd9))
      |-> $past(protMode && memOp && instClass != 2'd1));

  assert_mf_class_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && trapVector == 8'd16) |-> $past(fpErrPending && instClass != 2'd2));

endmodule

// File: tb/cop_trap_dispatch_tb.sv
module cop_trap_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [1:0]  instClass = 2'd0;
  logic        ctlEm = 1'b0, ctlTs = 1'b0, fpErrPending = 1'b0;
  logic        protMode = 1'b0, memOp = 1'b0, expandDown = 1'b0;
  logic [15:0] opOffset = '0, segLimit = '0;
  logic [3:0]  opLen = 4'd2;
  logic        trapValid, issuePermit;
  logic [7:0]  trapVector;

  int checks = 0, errors = 0;
  bit pending = 0;
  int expVec;            // -1 = issue, -2 = idle, else vector
  string expTag;
  bit finished = 0;

  always #5 clk = ~clk;

  cop_trap_dispatch dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .ctlEm(ctlEm), .ctlTs(ctlTs), .fpErrPending(fpErrPending),
    .protMode(protMode), .memOp(memOp), .opOffset(opOffset), .opLen(opLen),
    .segLimit(segLimit), .expandDown(expandDown),
    .trapValid(trapValid), .trapVector(trapVector), .issuePermit(issuePermit)
  );

  function automatic bit badByte(int a, int lim, bit down);
    return down ? !(a > lim) : !(a <= lim);
  endfunction

  // Behavioural reference: -1 means issue
  function automatic int refVec(bit [1:0] cls, bit em, bit ts, bit err, bit prot,
                                bit mem, int off, int len, int lim, bit down);
    bit firstBad = 0, anyBad = 0, wraps;
    if ((em && cls != 2'd1) || ts) return 7;
    if (prot && mem && cls != 2'd1) begin
      for (int i = 0; i < len; i++) begin
        bit b = badByte((off + i) % 65536, lim, down);
        if (b) anyBad = 1;
        if (b && i < 2) firstBad = 1;
      end
      wraps = (off + len) > 65536;
      if (firstBad || (anyBad && !wraps)) return 13;
      if (anyBad) return 9;
    end
    if (err && cls != 2'd2) return 16;
    return -1;
  endfunction

  task automatic compare();
    int gotV, gotT, gotI, eT, eI, eV;
    if (!pending) return;
    eT = (expVec >= 0); eI = (expVec == -1); eV = (expVec >= 0) ? expVec : 0;
    gotT = trapValid; gotI = issuePermit; gotV = trapVector;
    checks++;
    if (gotT != eT || gotI != eI || gotV != eV) begin
      errors++;
      $display("FAIL %s: trap=%0d vec=%0d issue=%0d expected trap=%0d vec=%0d issue=%0d",
               expTag, gotT, gotV, gotI, eT, eV, eI);
    end
  endtask

  task automatic apply(string tag, bit [1:0] cls, bit em, bit ts, bit err, bit prot,
                       bit mem, int off, int len, int lim, bit down);
    @(negedge clk);
    compare();
    instValid = 1; instClass = cls; ctlEm = em; ctlTs = ts; fpErrPending = err;
    protMode = prot; memOp = mem; opOffset = 16'(off); opLen = 4'(len);
    segLimit = 16'(lim); expandDown = down;
    expVec = refVec(cls, em, ts, err, prot, mem, off, len, lim, down);
    expTag = tag; pending = 1;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    compare();
    instValid = 0; ctlEm = 1; fpErrPending = 1;
    expVec = -2; expTag = tag; pending = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: outputs quiet through reset
    repeat (3) @(negedge clk);
    checks++;
    if (trapValid !== 1'b0 || issuePermit !== 1'b0 || trapVector !== 8'd0) begin
      errors++;
      $display("FAIL R10: trap=%0d vec=%0d issue=%0d expected 0 0 0", trapValid, trapVector, issuePermit);
    end
    rstN = 1;
    idle("R10");

    // R1 emulate bit
    apply("R1", 2'd0, 1, 0, 0, 0, 0, 0, 2, 0, 0);
    apply("R1", 2'd1, 1, 0, 0, 0, 0, 0, 2, 0, 0);
    apply("R1", 2'd2, 1, 0, 0, 0, 0, 0, 2, 0, 0);
    apply("R1", 2'd3, 1, 0, 0, 0, 0, 0, 2, 0, 0);
    // R2 task switched
    apply("R2", 2'd1, 0, 1, 0, 0, 0, 0, 2, 0, 0);
    apply("R2", 2'd2, 0, 1, 0, 0, 0, 0, 2, 0, 0);
    // R3 first word / tail overrun, expand-up
    apply("R3", 2'd0, 0, 0, 0, 1, 1, 16'h1000, 4, 16'h1000, 0);
    apply("R3", 2'd0, 0, 0, 0, 1, 1, 16'h0FF0, 10, 16'h1000, 0);
    apply("R3", 2'd0, 0, 0, 0, 1, 1, 16'h0FFA, 10, 16'h1000, 0);
    apply("R3", 2'd0, 0, 0, 0, 0, 1, 16'h0FFA, 10, 16'h1000, 0);
    // R4 wrap cases
    apply("R4", 2'd0, 0, 0, 0, 1, 1, 16'hFFFC, 8, 16'hFFFD, 0);
    apply("R4", 2'd0, 0, 0, 0, 1, 1, 16'hFFFC, 8, 16'hFFFF, 0);
    apply("R4", 2'd0, 0, 0, 0, 1, 1, 16'hFFFF, 2, 16'hFFFD, 0);
    apply("R4", 2'd2, 0, 0, 0, 1, 1, 16'hFFF8, 10, 16'hFFFA, 0);
    // R5 expand-down
    apply("R5", 2'd0, 0, 0, 0, 1, 1, 16'h8000, 8, 16'h7FFF, 1);
    apply("R5", 2'd0, 0, 0, 0, 1, 1, 16'h7FFF, 8, 16'h7FFF, 1);
    apply("R5", 2'd0, 0, 0, 0, 1, 1, 16'hFFFC, 8, 16'h7FFF, 1);
    apply("R5", 2'd0, 0, 0, 0, 1, 1, 16'hFFFE, 2, 16'h0000, 1);
    // R6 pending error
    apply("R6", 2'd0, 0, 0, 1, 0, 0, 0, 2, 0, 0);
    apply("R6", 2'd1, 0, 0, 1, 0, 0, 0, 2, 0, 0);
    apply("R6", 2'd2, 0, 0, 1, 1, 1, 16'h0010, 10, 16'hFFFF, 0);
    // R7 priority
    apply("R7", 2'd0, 0, 1, 1, 1, 1, 16'h2000, 4, 16'h1000, 0);
    apply("R7", 2'd0, 0, 0, 1, 1, 1, 16'h2000, 4, 16'h1000, 0);
    apply("R7", 2'd0, 0, 0, 1, 1, 1, 16'hFFFC, 8, 16'hFFFD, 0);
    // R9 no segment check for WAIT or register forms
    apply("R9", 2'd1, 0, 0, 0, 1, 1, 16'h2000, 4, 16'h1000, 0);
    apply("R9", 2'd0, 0, 0, 0, 1, 0, 16'h2000, 4, 16'h1000, 0);
    // R8 strobes do not repeat, idle gives nothing
    idle("R8");
    idle("R8");
    apply("R8", 2'd0, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    idle("R8");
    // R11 mixed lengths and offsets near the top of the space
    for (int n = 0; n < 600; n++) begin
      int lens[4] = '{2, 4, 8, 10};
      int off = ($urandom % 2) ? (65520 + $urandom % 16) : ($urandom % 65536);
      int lim = ($urandom % 2) ? (65520 + $urandom % 16) : ($urandom % 65536);
      bit [1:0] cls = 2'($urandom % 4);
      if ($urandom % 8 == 0) idle("R8");
      else apply("R11", cls, ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 3) == 0,
                 ($urandom % 4) != 0, ($urandom % 5) != 0, off, lens[$urandom % 4], lim,
                 ($urandom % 3) == 0);
    end
    idle("R8");
    @(negedge clk);
    compare();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule